// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave

This block is a slave on a two-wire serial bus (SCL clock, SDA data). Both bus lines are oversampled on the system clock. The block answers at the 7-bit address formed by the fixed prefix 1001 and three strap pins. It gives a host access to a small register file through an 8-bit pointer that the host can only write. The pointer is sticky: once set, it keeps its value across transactions. A later read that does not write a pointer uses the last selection.

The file holds four registers:
- a read-only temperature value taken from an input port,
- a configuration byte,
- a low threshold,
- a high threshold.

Each of the three 9-bit values travels as two bytes, most significant byte first, with the value left-justified in 16 bits. The block drives SDA only by pulling it low, through a pull-down enable. A one-cycle strobe marks the end of every register read, so that neighbouring alarm logic can clear itself.

The register outputs and the strobe are plain level and pulse signals. None of them has back-pressure: the host paces every transfer through SCL, and the block never stretches the clock.

Top module: `ptr_reg_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal {1001, addr_sel[2:0]}, with bit 0 as read (1) or write (0). It also acknowledges every byte written after that. For any other address it never pulls SDA until the next start condition.
- R2: A start (SDA falls while SCL is high) restarts address reception from any state, including a repeated start in mid-transfer. A stop (SDA rises while SCL is high) returns the block to idle. The pull-down enable changes only while the synchronised SCL is low.
- R3: The first byte written after the address is the pointer. Bits 1:0 select the register: 00 temperature, 01 configuration, 10 low threshold, 11 high threshold. If bits 7:2 are not all zero, the byte is still acknowledged, but the pointer keeps its old value and every further byte of that write is discarded.
- R4: For the two threshold registers, the first data byte supplies value bits 8:1 and bit 7 of the second data byte supplies value bit 0. The register changes only when the second byte is acknowledged. Bytes after the second are ignored.
- R5: A configuration write stores data bits 4:0; bits 7:5 always read as zero. Bytes after the first configuration byte are ignored.
- R6: Data bytes written while the pointer selects the temperature register are acknowledged, but no register changes.
- R7: Reads are sent MSB first.
  - A 9-bit register v returns {v[8:1]} and then {v[0], 7'b0}, and repeats this pair while the host keeps acknowledging.
  - The configuration register returns its byte for every byte read.
- R8: The pointer persists across stop conditions. A read with no pointer write uses the last valid pointer. A pointer write followed by a repeated start and a read returns the newly selected register.
- R9: When the host does not acknowledge a read byte, the block releases SDA and ignores SCL until the next start or stop. On that not-acknowledge it raises rd_strobe for exactly one clock, and only then.
- R10: After reset the configuration output is 0x00, the high threshold is 160, the low threshold is 150, the pointer is 00, SDA is released and rd_strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel | input | 3 | Low three bits of the slave address |
| temp_val | input | 9 | Two's-complement temperature, half-degree units |
| cfg_out | output | 8 | Configuration byte, bits 7:5 zero |
| tset_out | output | 9 | High threshold value |
| thyst_out | output | 9 | Low threshold value |
| rd_strobe | output | 1 | One-cycle pulse that ends a register read |

## Verification
A wrong bit counter or wrong state in the transfer engine shows up within one byte. It appears at the ports as a missing or misplaced acknowledge, or as read bytes shifted by one bit position. A pointer or write-index fault stays hidden until the next read, when the wrong register or byte half comes back. An ignored-write fault is caught at once by checking the register outputs and reading back through the bus. A fault in the strobe logic is seen at the single clock where the host's not-acknowledge is sampled.

// File: rtl/ptr_slave_pkg.sv
package ptr_slave_pkg;
  typedef enum logic [1:0] {
    SEL_TEMP = 2'b00,
    SEL_CFG  = 2'b01,
    SEL_LOW  = 2'b10,
    SEL_HIGH = 2'b11
  } reg_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_RD_NEXT
  } xfer_st_e;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
endpackage

// File: rtl/ps_bus_sense.sv
module ps_bus_sense #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_pin,
  input  logic sda_pin,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [DEPTH-1:0] scl_ch, sda_ch;
  logic scl_prev, sda_prev, scl_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ch   <= '1;
      sda_ch   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_ch   <= {scl_ch[DEPTH-2:0], scl_pin};
      sda_ch   <= {sda_ch[DEPTH-2:0], sda_pin};
      scl_prev <= scl_ch[DEPTH-1];
      sda_prev <= sda_ch[DEPTH-1];
    end
  end

  assign scl_lvl   = scl_ch[DEPTH-1];
  assign sda_lvl   = sda_ch[DEPTH-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/ps_xfer_fsm.sv
module ps_xfer_fsm
  import ptr_slave_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [6:0]        dev_addr,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              rd_idx,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_data,
  output logic [1:0]        wr_idx,
  output logic              sda_pull,
  output logic              rd_done
);
  xfer_st_e          state;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] sh, tx;
  logic              rw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      rw      <= 1'b0;
      rd_idx  <= 1'b0;
      wr_idx  <= '0;
      rd_done <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      if (start_det) begin
        state <= ST_ADDR;
        cnt   <= '0;
      end else if (stop_det) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_lvl};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (sh[7:1] == dev_addr) begin
                state  <= ST_ADDR_ACK;
                rw     <= sh[0];
                rd_idx <= 1'b0;
                wr_idx <= '0;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              tx     <= rd_byte;
              rd_idx <= ~rd_idx;
              state  <= ST_RD;
            end else begin
              state <= ST_WR;
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_lvl};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              state <= ST_WR_ACK;
              if (wr_idx != 2'd3) wr_idx <= wr_idx + 2'd1;
            end
          end
          ST_WR_ACK: if (scl_fall) begin
            cnt   <= '0;
            state <= ST_WR;
          end
          ST_RD: if (scl_fall) begin
            if (cnt == 4'd7) begin
              state <= ST_RD_ACK;
            end else begin
              tx  <= {tx[BYTE_W-2:0], 1'b0};
              cnt <= cnt + 4'd1;
            end
          end
          ST_RD_ACK: if (scl_rise) begin
            if (sda_lvl) begin
              state   <= ST_IDLE;
              rd_done <= 1'b1;
            end else begin
              state <= ST_RD_NEXT;
            end
          end
          ST_RD_NEXT: if (scl_fall) begin
            tx     <= rd_byte;
            rd_idx <= ~rd_idx;
            cnt    <= '0;
            state  <= ST_RD;
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_stb   = (state == ST_WR) && scl_fall && (cnt == 4'd8) && !start_det && !stop_det;
  assign wr_data  = sh;
  assign sda_pull = (state == ST_ADDR_ACK) || (state == ST_WR_ACK) ||
                    ((state == ST_RD) && !tx[BYTE_W-1]);
endmodule

// File: rtl/ps_reg_bank.sv
module ps_reg_bank
  import ptr_slave_pkg::*;
#(
  parameter int               VAL_W    = 9,
  parameter logic [VAL_W-1:0] HIGH_RST = 9'd160,
  parameter logic [VAL_W-1:0] LOW_RST  = 9'd150
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [1:0]        wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_idx,
  input  logic [VAL_W-1:0]  temp_val,
  output logic [BYTE_W-1:0] cfg_q,
  output logic [VAL_W-1:0]  high_q,
  output logic [VAL_W-1:0]  low_q,
  output logic [BYTE_W-1:0] rd_byte
);
  localparam int PAD = WORD_W - VAL_W;
  localparam int LSB_W = VAL_W - BYTE_W;

  reg_sel_e          ptr;
  logic              ptr_ok;
  logic [BYTE_W-1:0] stage;
  logic [VAL_W-1:0]  sel_val;
  logic [WORD_W-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= SEL_TEMP;
      ptr_ok <= 1'b0;
      stage  <= '0;
      cfg_q  <= '0;
      high_q <= HIGH_RST;
      low_q  <= LOW_RST;
    end else if (wr_stb) begin
      case (wr_idx)
        2'd0: begin
          ptr_ok <= (wr_data[7:2] == 6'd0);
          if (wr_data[7:2] == 6'd0) ptr <= reg_sel_e'(wr_data[1:0]);
        end
        2'd1: if (ptr_ok) begin
          if (ptr == SEL_CFG) cfg_q <= {3'b000, wr_data[4:0]};
          else                stage <= wr_data;
        end
        2'd2: if (ptr_ok) begin
          if (ptr == SEL_HIGH) high_q <= {stage, wr_data[BYTE_W-1 -: LSB_W]};
          if (ptr == SEL_LOW)  low_q  <= {stage, wr_data[BYTE_W-1 -: LSB_W]};
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (ptr)
      SEL_HIGH: sel_val = high_q;
      SEL_LOW:  sel_val = low_q;
      default:  sel_val = temp_val;
    endcase
    word = {sel_val, {PAD{1'b0}}};
    if (ptr == SEL_CFG) rd_byte = cfg_q;
    else if (rd_idx)    rd_byte = word[BYTE_W-1:0];
    else                rd_byte = word[WORD_W-1 -: BYTE_W];
  end
endmodule

// File: rtl/ptr_reg_slave.sv
module ptr_reg_slave #(
  parameter int         SYNC_DEPTH = 2,
  parameter int         VAL_W      = 9,
  parameter logic [3:0] ADDR_HI    = 4'b1001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_pull,
  input  logic [2:0]       addr_sel,
  input  logic [VAL_W-1:0] temp_val,
  output logic [7:0]       cfg_out,
  output logic [VAL_W-1:0] tset_out,
  output logic [VAL_W-1:0] thyst_out,
  output logic             rd_strobe
);
  logic       sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic       rd_idx, wr_stb;
  logic [7:0] wr_data, rd_byte;
  logic [1:0] wr_idx;

  ps_bus_sense #(.DEPTH(SYNC_DEPTH)) u_sense (
    .clk(clk), .rst_n(rst_n), .scl_pin(scl_in), .sda_pin(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ps_xfer_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .dev_addr({ADDR_HI, addr_sel}), .rd_byte(rd_byte), .rd_idx(rd_idx),
    .wr_stb(wr_stb), .wr_data(wr_data), .wr_idx(wr_idx),
    .sda_pull(sda_pull), .rd_done(rd_strobe)
  );

  ps_reg_bank #(.VAL_W(VAL_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .temp_val(temp_val),
    .cfg_q(cfg_out), .high_q(tset_out), .low_q(thyst_out), .rd_byte(rd_byte)
  );
endmodule

// File: rtl/ptr_reg_slave_chk.sv
module ptr_reg_slave_chk #(
  parameter int SYNC_DEPTH = 2,
  parameter int VAL_W      = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_in,
  input logic             sda_pull,
  input logic             rd_strobe,
  input logic [7:0]       cfg_out,
  input logic [VAL_W-1:0] tset_out,
  input logic [VAL_W-1:0] thyst_out
);
  logic [SYNC_DEPTH-1:0] scl_mirror;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_mirror <= '1;
    else        scl_mirror <= {scl_mirror[SYNC_DEPTH-2:0], scl_in};
  end

  // R2
  pull_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !$past(scl_mirror[SYNC_DEPTH-1]));

  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !rd_strobe);

  // R9
  strobe_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> !sda_pull);

  // R4
  high_update_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tset_out != $past(tset_out)) |-> sda_pull);

  // R4
  low_update_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thyst_out != $past(thyst_out)) |-> sda_pull);

  // R5
  cfg_update_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_out != $past(cfg_out)) |-> sda_pull);
endmodule

bind ptr_reg_slave ptr_reg_slave_chk #(.SYNC_DEPTH(SYNC_DEPTH), .VAL_W(VAL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_pull(sda_pull),
  .rd_strobe(rd_strobe), .cfg_out(cfg_out), .tset_out(tset_out),
  .thyst_out(thyst_out)
);

// File: tb/ptr_reg_slave_tb.sv
`timescale 1ns/1ps
module ptr_reg_slave_tb;
  localparam int QTR = 200;
  localparam logic [2:0] PINS = 3'b101;
  localparam logic [6:0] DEV = {4'b1001, PINS};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_pull, rd_strobe;
  logic [7:0] cfg_out;
  logic [8:0] tset_out, thyst_out;
  logic [8:0] temp_val = 9'h1B0;
  wire  bus_sda = sda_m & ~sda_pull;
  int checks = 0, fails = 0, strobes = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ptr_reg_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(bus_sda), .sda_pull(sda_pull),
    .addr_sel(PINS), .temp_val(temp_val), .cfg_out(cfg_out),
    .tset_out(tset_out), .thyst_out(thyst_out), .rd_strobe(rd_strobe)
  );

  always @(posedge clk) if (rd_strobe) strobes <= strobes + 1;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #QTR; scl = 1'b1; #QTR; sda_m = 1'b0; #QTR; scl = 1'b0; #QTR;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #QTR; scl = 1'b1; #QTR; sda_m = 1'b1; #QTR;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #QTR; scl = 1'b1; #(2*QTR); scl = 1'b0; #QTR;
    end
    sda_m = 1'b1; #QTR; scl = 1'b1; #QTR; ack = ~bus_sda; #QTR; scl = 1'b0; #QTR;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; #QTR; scl = 1'b1; #QTR; b[i] = bus_sda; #QTR; scl = 1'b0; #QTR;
    end
    sda_m = nack; #QTR; scl = 1'b1; #(2*QTR); scl = 1'b0; #QTR;
  endtask

  task automatic write_seq(input string req, input logic [7:0] ptr, input logic [7:0] d0,
                           input logic [7:0] d1, input int n);
    logic a;
    bus_start();
    send_byte({DEV, 1'b0}, a); check({req, " addr ack"}, 16'(a), 16'd1);
    send_byte(ptr, a);         check({req, " ptr ack"}, 16'(a), 16'd1);
    if (n > 0) begin send_byte(d0, a); check({req, " d0 ack"}, 16'(a), 16'd1); end
    if (n > 1) begin send_byte(d1, a); check({req, " d1 ack"}, 16'(a), 16'd1); end
    if (n > 2) begin send_byte(8'hFF, a); check({req, " extra ack"}, 16'(a), 16'd1); end
    bus_stop();
  endtask

  task automatic read_seq(input string req, input bit set_ptr, input logic [7:0] ptr,
                          input int n, input logic [7:0] e0, input logic [7:0] e1,
                          input logic [7:0] e2);
    logic a;
    logic [7:0] b;
    int s0;
    s0 = strobes;
    if (set_ptr) begin
      bus_start();
      send_byte({DEV, 1'b0}, a); check({req, " waddr ack"}, 16'(a), 16'd1);
      send_byte(ptr, a);         check({req, " ptr ack"}, 16'(a), 16'd1);
    end
    bus_start();
    send_byte({DEV, 1'b1}, a); check({req, " raddr ack"}, 16'(a), 16'd1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, b);
      check({req, " data"}, 16'(b), 16'(k == 0 ? e0 : (k == 1 ? e1 : e2)));
    end
    bus_stop();
    #(4*QTR);
    check({req, " R9 strobe count"}, 16'(strobes - s0), 16'd1);
  endtask

  task automatic t_reset();
    check("R10 cfg", 16'(cfg_out), 16'h00);
    check("R10 high", 16'(tset_out), 16'd160);
    check("R10 low", 16'(thyst_out), 16'd150);
    check("R10 pull", 16'(sda_pull), 16'd0);
    check("R10 strobe", 16'(rd_strobe), 16'd0);
  endtask

  task automatic t_mismatch();
    logic a;
    bus_start(); send_byte({4'b1001, 3'b100, 1'b0}, a); bus_stop();
    check("R1 pin mismatch nack", 16'(a), 16'd0);
    bus_start(); send_byte({4'b1011, PINS, 1'b1}, a); bus_stop();
    check("R1 prefix mismatch nack", 16'(a), 16'd0);
  endtask

  task automatic t_nack_release();
    logic [7:0] b;
    logic a;
    int s0;
    s0 = strobes;
    bus_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(1'b1, b);
    check("R9 first byte", 16'(b), 16'h1F);
    recv_byte(1'b1, b);
    check("R9 released after nack", 16'(b), 16'hFF);
    bus_stop();
    #(4*QTR);
    check("R9 single strobe", 16'(strobes - s0), 16'd1);
  endtask

  initial begin
    #100 rst_n = 1'b1;
    #(2*QTR);
    t_reset();
    t_mismatch();
    read_seq("R10 R8 default high", 1, 8'h03, 2, 8'h50, 8'h00, 8'h00);
    write_seq("R5 cfg write", 8'h01, 8'hFF, 8'h00, 2);
    check("R5 cfg value", 16'(cfg_out), 16'h1F);
    write_seq("R4 high write", 8'h03, 8'h32, 8'h80, 3);
    check("R4 high value", 16'(tset_out), 16'h065);
    write_seq("R4 low write", 8'h02, 8'hCE, 8'h00, 2);
    check("R4 low value", 16'(thyst_out), 16'h19C);
    check("R4 high kept", 16'(tset_out), 16'h065);
    read_seq("R7 R8 high wrap", 1, 8'h03, 3, 8'h32, 8'h80, 8'h32);
    read_seq("R7 low read", 1, 8'h02, 2, 8'hCE, 8'h00, 8'h00);
    write_seq("R8 ptr only", 8'h01, 8'h00, 8'h00, 0);
    read_seq("R8 R7 cfg preset", 0, 8'h00, 2, 8'h1F, 8'h1F, 8'h00);
    write_seq("R6 temp write", 8'h00, 8'h11, 8'h22, 2);
    check("R6 high unchanged", 16'(tset_out), 16'h065);
    check("R6 low unchanged", 16'(thyst_out), 16'h19C);
    check("R6 cfg unchanged", 16'(cfg_out), 16'h1F);
    read_seq("R6 R8 temp read", 0, 8'h00, 2, 8'hD8, 8'h00, 8'h00);
    write_seq("R3 bad ptr", 8'h07, 8'hAA, 8'h55, 2);
    check("R3 high unchanged", 16'(tset_out), 16'h065);
    read_seq("R3 ptr kept", 0, 8'h00, 2, 8'hD8, 8'h00, 8'h00);
    write_seq("R2 set cfg ptr", 8'h01, 8'h00, 8'h00, 0);
    t_nack_release();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule